// File: doc/BRIEF.md
# Verified Boot Sequencer

This block is the control core of a verified boot path. After reset it walks a fixed chain of trust before it lets the processor start. It does no cryptography of its own. It asks outside engines for work through request/done/pass handshakes. A hash engine returns a 256-bit digest. A checksum engine and a signature engine each return a pass flag. While a request is raised, the block also presents the byte region that the engine must cover and the key that the signature engine must use.

The check starts from a secure-enable fuse bit. When that bit is clear, no check is made and boot is released at once. When it is set, the block works through these steps in order:

1. the security header checksum;
2. the choice of a code-signing key, taken from sixteen candidates under a revocation mask;
3. the root-key digest, compared with a fuse value;
4. the key-array signature, checked under the root key;
5. the header signature;
6. the image checksum;
7. the image signature.

The header signature and the image signature are both checked under the chosen key. When the whole chain passes, the block issues a single boot-go pulse. Any failure, or an engine that stays silent for too long, parks the block in a fail state with a 4-bit code, and it stays there until reset.

Top module: `vboot_seq`

## Requirements
- R1: With `sec_en` low, `boot_go` pulses in the first cycle after reset release, and no engine request is ever raised.
- R2: With `sec_en` high, the first request is a checksum over the security header region (offset `SEC_OFF`, length `SEC_BYTES`). A failing result latches fail code 1.
- R3: The key in use is the lowest index i with `revoke_mask[i]` = 0, where a bit at 1 means revoked. It appears on `key_idx` during the header and image signature requests.
- R4: If all sixteen mask bits are 1, the block fails with code 2 and never raises `sig_req`.
- R5: The root-key digest step requests a hash over the root key record (offset `SEC_OFF+ROOT_REL`, 524 bytes). It passes only when `hash_value` equals `fuse_digest` in all 256 bits; otherwise it fails with code 3.
- R6: After the digest step, the checks run in a fixed order, with these regions, key selections and fail codes:
  - key-array signature: `sig_root_key`=1, region `HDR_BYTES-8384` / 8384, fail code 4;
  - header signature: selected key, region 0 / `HDR_BYTES-8384`, fail code 5;
  - image checksum: region `HDR_BYTES` / `IMG_BYTES`, fail code 6;
  - image signature: selected key, same region, fail code 7.
- R7: At most one request is high at a time. A request stays high until its engine's done arrives, the step fails, or the watchdog fires.
- R8: With `wdog_limit` = L (L ≥ 1), a step passes if done arrives within the first L cycles of its request. Otherwise the block fails with code 8 + step code.
- R9: After reset `fail` and `fail_code` are 0. Once `fail` rises, it stays high with a stable code and no requests or `boot_go` until reset.
- R10: `boot_go` is a one-cycle pulse. It follows a passing image signature (or the bypass of R1), after which the block idles with no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_en | input | 1 | Secure-enable fuse bit |
| revoke_mask | input | NUM_KEYS | Bit i set marks key i revoked |
| fuse_digest | input | DIG_W | Expected root-key digest from fuses |
| wdog_limit | input | WD_W | Per-step done timeout in cycles |
| hash_req | output | 1 | Hash engine request |
| hash_done | input | 1 | Hash engine done strobe |
| hash_value | input | DIG_W | Hash engine result |
| sum_req | output | 1 | Checksum engine request |
| sum_done | input | 1 | Checksum engine done strobe |
| sum_ok | input | 1 | Checksum pass flag, valid with done |
| sig_req | output | 1 | Signature engine request |
| sig_done | input | 1 | Signature engine done strobe |
| sig_ok | input | 1 | Signature pass flag, valid with done |
| sig_root_key | output | 1 | Signature engine must use the root key |
| key_idx | output | KEY_W | Selected code-signing key index |
| region_off | output | ADDR_W | Byte offset of region under check |
| region_len | output | ADDR_W | Byte length of region under check |
| boot_go | output | 1 | One-cycle boot release pulse |
| fail | output | 1 | Terminal failure flag |
| fail_code | output | 4 | Failed step code, bit 3 marks timeout |

## Verification
Two situations are hard to reach from the ports:

- The watchdog boundary, where done arrives in the last cycle allowed or one cycle late. The bench's engine responders take a programmable response delay, and the runs set it to L-1 and to L against a limit of L.
- A failure deep in the chain. The responders can also refuse a chosen step's result or never answer it, so every fail code and the timeout path at the header signature step are each reached on their own. A fully revoked mask is applied to show that the signature engine is never asked.

// File: rtl/vboot_pkg.sv
package vboot_pkg;

   // State codes double as fail codes for the step they name.
   typedef enum logic [3:0] {
      ST_CHK   = 4'd0,
      ST_HSUM  = 4'd1,
      ST_PICK  = 4'd2,
      ST_RHASH = 4'd3,
      ST_ASIG  = 4'd4,
      ST_HSIG  = 4'd5,
      ST_ISUM  = 4'd6,
      ST_ISIG  = 4'd7,
      ST_GO    = 4'd8,
      ST_DONE  = 4'd9,
      ST_FAIL  = 4'd10
   } vb_state_e;

   typedef enum logic [1:0] {
      ENG_NONE = 2'd0,
      ENG_HASH = 2'd1,
      ENG_SUM  = 2'd2,
      ENG_SIG  = 2'd3
   } vb_eng_e;

   localparam logic [3:0] TMO_FLAG = 4'b1000;

   function automatic vb_eng_e eng_of(vb_state_e s);
      case (s)
         ST_RHASH:                  return ENG_HASH;
         ST_HSUM, ST_ISUM:          return ENG_SUM;
         ST_ASIG, ST_HSIG, ST_ISIG: return ENG_SIG;
         default:                   return ENG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/vboot_key_pick.sv
module vboot_key_pick #(
   parameter int NUM_KEYS = 16,
   parameter int KEY_W    = $clog2(NUM_KEYS)
) (
   input  logic [NUM_KEYS-1:0] revoked,
   output logic                any_valid,
   output logic [KEY_W-1:0]    idx
);

   logic [NUM_KEYS:0]   seen;
   logic [NUM_KEYS-1:0] grant;
   logic [NUM_KEYS-1:0] low_mask;

   assign seen[0] = 1'b0;

   generate
      for (genvar g = 0; g < NUM_KEYS; g++) begin : g_chain
         assign seen[g+1] = seen[g] | ~revoked[g];
         assign grant[g]  = ~revoked[g] & ~seen[g];
      end
   endgenerate

   assign any_valid = seen[NUM_KEYS];

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (grant[i]) idx = KEY_W'(i);
      end
   end

   always_comb begin
      low_mask = ({{(NUM_KEYS-1){1'b0}}, 1'b1} << idx) - 1'b1;
      if (any_valid) begin
         // R3: chosen key is live and every lower key is revoked
         a_r3_lowest_live: assert (!revoked[idx] && ((revoked & low_mask) == low_mask));
      end
   end

endmodule

// File: rtl/vboot_step_wdog.sv
module vboot_step_wdog #(
   parameter int WD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            done,
   input  logic [WD_W-1:0] limit,
   output logic            expire
);

   logic [WD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || done) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && !done && (cnt_q == limit - 1'b1);

   // R8: count never passes the programmed window while a step waits
   a_r8_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (run && limit != '0) |-> (cnt_q < limit));

   // R8: an expiry always ends the waiting step
   a_r8_expire_ends_step: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !run);

endmodule

// File: rtl/vboot_region_map.sv
module vboot_region_map
   import vboot_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int NUM_KEYS  = 16,
   parameter int KEY_BYTES = 524,
   parameter int HDR_BYTES = 12288,
   parameter int SEC_OFF   = 512,
   parameter int SEC_BYTES = 1024,
   parameter int ROOT_REL  = 64,
   parameter int IMG_BYTES = 65536
) (
   input  vb_state_e         step,
   output logic [ADDR_W-1:0] off,
   output logic [ADDR_W-1:0] len
);

   localparam int ARR_BYTES = KEY_BYTES * NUM_KEYS;
   localparam int ARR_OFF   = HDR_BYTES - ARR_BYTES;
   localparam int ROOT_OFF  = SEC_OFF + ROOT_REL;

   always_comb begin
      off = '0;
      len = '0;
      case (step)
         ST_HSUM: begin
            off = ADDR_W'(SEC_OFF);
            len = ADDR_W'(SEC_BYTES);
         end
         ST_RHASH: begin
            off = ADDR_W'(ROOT_OFF);
            len = ADDR_W'(KEY_BYTES);
         end
         ST_ASIG: begin
            off = ADDR_W'(ARR_OFF);
            len = ADDR_W'(ARR_BYTES);
         end
         ST_HSIG: begin
            off = '0;
            len = ADDR_W'(ARR_OFF);
         end
         ST_ISUM, ST_ISIG: begin
            off = ADDR_W'(HDR_BYTES);
            len = ADDR_W'(IMG_BYTES);
         end
         default: begin
            off = '0;
            len = '0;
         end
      endcase
   end

endmodule

// File: rtl/vboot_seq.sv
module vboot_seq
   import vboot_pkg::*;
#(
   parameter int NUM_KEYS  = 16,
   parameter int DIG_W     = 256,
   parameter int ADDR_W    = 20,
   parameter int WD_W      = 16,
   parameter int KEY_BYTES = 524,
   parameter int HDR_BYTES = 12288,
   parameter int SEC_OFF   = 512,
   parameter int SEC_BYTES = 1024,
   parameter int ROOT_REL  = 64,
   parameter int IMG_BYTES = 65536,
   localparam int KEY_W    = $clog2(NUM_KEYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sec_en,
   input  logic [NUM_KEYS-1:0] revoke_mask,
   input  logic [DIG_W-1:0]    fuse_digest,
   input  logic [WD_W-1:0]     wdog_limit,
   output logic                hash_req,
   input  logic                hash_done,
   input  logic [DIG_W-1:0]    hash_value,
   output logic                sum_req,
   input  logic                sum_done,
   input  logic                sum_ok,
   output logic                sig_req,
   input  logic                sig_done,
   input  logic                sig_ok,
   output logic                sig_root_key,
   output logic [KEY_W-1:0]    key_idx,
   output logic [ADDR_W-1:0]   region_off,
   output logic [ADDR_W-1:0]   region_len,
   output logic                boot_go,
   output logic                fail,
   output logic [3:0]          fail_code
);

   generate
      if (NUM_KEYS < 2) begin : g_bad_keys
         $error("vboot_seq: NUM_KEYS must be at least 2");
      end
      if (KEY_BYTES * NUM_KEYS > HDR_BYTES - SEC_OFF - SEC_BYTES) begin : g_bad_arr
         $error("vboot_seq: key array does not fit behind the security header");
      end
      if (ROOT_REL + KEY_BYTES > SEC_BYTES) begin : g_bad_root
         $error("vboot_seq: root key record exceeds the security header");
      end
      if (HDR_BYTES + IMG_BYTES >= 2 ** ADDR_W) begin : g_bad_addr
         $error("vboot_seq: ADDR_W too narrow for header plus image");
      end
   endgenerate

   vb_state_e        state_q, state_d;
   logic [3:0]       code_q, code_d;
   logic [KEY_W-1:0] key_q, key_d;
   vb_eng_e          eng;
   logic             in_wait, step_done, step_ok;
   logic             wd_expire, any_valid;
   logic [KEY_W-1:0] pick_idx;

   vboot_key_pick #(
      .NUM_KEYS (NUM_KEYS),
      .KEY_W    (KEY_W)
   ) key_pick_i (
      .revoked   (revoke_mask),
      .any_valid (any_valid),
      .idx       (pick_idx)
   );

   vboot_step_wdog #(
      .WD_W (WD_W)
   ) wdog_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (in_wait),
      .done   (step_done),
      .limit  (wdog_limit),
      .expire (wd_expire)
   );

   vboot_region_map #(
      .ADDR_W    (ADDR_W),
      .NUM_KEYS  (NUM_KEYS),
      .KEY_BYTES (KEY_BYTES),
      .HDR_BYTES (HDR_BYTES),
      .SEC_OFF   (SEC_OFF),
      .SEC_BYTES (SEC_BYTES),
      .ROOT_REL  (ROOT_REL),
      .IMG_BYTES (IMG_BYTES)
   ) region_i (
      .step (state_q),
      .off  (region_off),
      .len  (region_len)
   );

   assign eng     = eng_of(state_q);
   assign in_wait = (eng != ENG_NONE);

   always_comb begin
      case (eng)
         ENG_HASH: begin
            step_done = hash_done;
            step_ok   = (hash_value == fuse_digest);
         end
         ENG_SUM: begin
            step_done = sum_done;
            step_ok   = sum_ok;
         end
         ENG_SIG: begin
            step_done = sig_done;
            step_ok   = sig_ok;
         end
         default: begin
            step_done = 1'b0;
            step_ok   = 1'b0;
         end
      endcase
   end

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      key_d   = key_q;
      case (state_q)
         ST_CHK: state_d = sec_en ? ST_HSUM : ST_GO;
         ST_PICK: begin
            if (any_valid) begin
               key_d   = pick_idx;
               state_d = ST_RHASH;
            end else begin
               state_d = ST_FAIL;
               code_d  = ST_PICK;
            end
         end
         ST_GO:            state_d = ST_DONE;
         ST_DONE, ST_FAIL: state_d = state_q;
         default: begin
            if (in_wait) begin
               if (step_done) begin
                  if (step_ok) begin
                     state_d = vb_state_e'(state_q + 4'd1);
                  end else begin
                     state_d = ST_FAIL;
                     code_d  = state_q;
                  end
               end else if (wd_expire) begin
                  state_d = ST_FAIL;
                  code_d  = TMO_FLAG | state_q;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_CHK;
         code_q  <= '0;
         key_q   <= '0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         key_q   <= key_d;
      end
   end

   assign hash_req     = (eng == ENG_HASH);
   assign sum_req      = (eng == ENG_SUM);
   assign sig_req      = (eng == ENG_SIG);
   assign sig_root_key = (state_q == ST_ASIG);
   assign key_idx      = key_q;
   assign boot_go      = (state_q == ST_GO);
   assign fail         = (state_q == ST_FAIL);
   assign fail_code    = code_q;

   // R7: engine requests never overlap
   a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hash_req, sum_req, sig_req}));

   // R7: a signature request holds until done or timeout
   a_r7_sig_held: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_req && !sig_done && !wd_expire) |=> sig_req);

   // R9: failure is terminal with a stable code
   a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> (fail && $stable(fail_code) && !boot_go));

   // R10: boot release lasts one cycle and nothing follows it
   a_r10_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      boot_go |=> (!boot_go && !fail && !hash_req && !sum_req && !sig_req));

   // R4: no live key leads straight to code 2
   a_r4_no_key_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PICK && !any_valid) |=> (fail && fail_code == 4'd2));

   // R1: fuse bit clear bypasses the chain
   a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHK && !sec_en) |=> boot_go);

endmodule

// File: tb/vboot_seq_tb_top.sv
module vboot_seq_tb_top;

   localparam int NK = 16;
   localparam logic [255:0] FUSE = {8{32'h5A17_C3E9}};
   localparam int SEC_OFF = 512, SEC_LEN = 1024, ROOT_OFF = 576, KEYB = 524;
   localparam int ARR_LEN = 16 * 524, HDR = 12288, ARR_OFF = HDR - ARR_LEN, IMG_LEN = 65536;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          sec_en = 1'b0;
   logic [NK-1:0] revoke_mask = '0;
   logic [255:0]  fuse_digest = FUSE;
   logic [15:0]   wdog_limit = 16'd20;
   logic          hash_done = 1'b0, sum_done = 1'b0, sig_done = 1'b0;
   logic          sum_ok = 1'b0, sig_ok = 1'b0;
   logic [255:0]  hash_value = FUSE;
   logic          hash_req, sum_req, sig_req, sig_root_key, boot_go, fail;
   logic [3:0]    key_idx, fail_code;
   logic [19:0]   region_off, region_len;

   vboot_seq dut_i (
      .clk (clk), .rst_n (rst_n), .sec_en (sec_en), .revoke_mask (revoke_mask),
      .fuse_digest (fuse_digest), .wdog_limit (wdog_limit),
      .hash_req (hash_req), .hash_done (hash_done), .hash_value (hash_value),
      .sum_req (sum_req), .sum_done (sum_done), .sum_ok (sum_ok),
      .sig_req (sig_req), .sig_done (sig_done), .sig_ok (sig_ok),
      .sig_root_key (sig_root_key), .key_idx (key_idx),
      .region_off (region_off), .region_len (region_len),
      .boot_go (boot_go), .fail (fail), .fail_code (fail_code)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   int mst = 0, mcnt = 0, mcode = 0, mkey = 0;
   int dly = 0, hang_step = -1, bad_step = -1, wcnt = 0;
   int go_cnt = 0, sig_cnt = 0, req_cnt = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic bit is_wait(int s);
      return (s == 1) || (s >= 3 && s <= 7);
   endfunction

   function automatic logic [63:0] eoff(int s);
      case (s)
         1: return SEC_OFF;
         3: return ROOT_OFF;
         4: return ARR_OFF;
         6, 7: return HDR;
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] elen(int s);
      case (s)
         1: return SEC_LEN;
         3: return KEYB;
         4: return ARR_LEN;
         5: return ARR_OFF;
         6, 7: return IMG_LEN;
         default: return 0;
      endcase
   endfunction

   // Behavioural reference: step number, wait counter, latched code
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         mst = 0; mcnt = 0; mcode = 0; mkey = 0;
      end else begin
         case (mst)
            0: mst = sec_en ? 1 : 8;
            2: begin
               int lo;
               lo = -1;
               for (int i = NK - 1; i >= 0; i--) if (!revoke_mask[i]) lo = i;
               if (lo < 0) begin mcode = 2; mst = 10; end
               else begin mkey = lo; mst = 3; end
            end
            8: mst = 9;
            9, 10: ;
            default: begin
               bit d, ok;
               d  = (mst == 3) ? hash_done : (mst == 1 || mst == 6) ? sum_done : sig_done;
               ok = (mst == 3) ? (hash_value == fuse_digest) :
                    (mst == 1 || mst == 6) ? sum_ok : sig_ok;
               if (d) begin
                  mcnt = 0;
                  if (ok) mst = mst + 1;
                  else begin mcode = mst; mst = 10; end
               end else if (mcnt == int'(wdog_limit) - 1) begin
                  mcode = 8 + mst; mst = 10; mcnt = 0;
               end else mcnt++;
            end
         endcase
      end
   end

   // Compare every cycle, then act as the engines
   always @(negedge clk) begin
      bit eh, es, eg;
      eh = (mst == 3);
      es = (mst == 1 || mst == 6);
      eg = (mst == 4 || mst == 5 || mst == 7);
      chk("R10 boot_go", boot_go, mst == 8);
      chk("R9 fail", fail, mst == 10);
      chk("R9 fail_code", fail_code, mcode);
      chk("R7 requests", {hash_req, sum_req, sig_req}, {eh, es, eg});
      if (eh || es || eg) begin
         chk("R6 region_off", region_off, eoff(mst));
         chk("R6 region_len", region_len, elen(mst));
      end
      if (eg) begin
         chk("R6 root key select", sig_root_key, mst == 4);
         if (mst != 4) chk("R3 key_idx", key_idx, mkey);
      end
      go_cnt  += boot_go;
      sig_cnt += sig_req;
      req_cnt += (hash_req | sum_req | sig_req);
      hash_done = 1'b0; sum_done = 1'b0; sig_done = 1'b0;
      if (rst_n && is_wait(mst) && mst != hang_step) begin
         if (wcnt >= dly) begin
            wcnt = 0;
            if (mst == 3) hash_done = 1'b1;
            else if (mst == 1 || mst == 6) begin sum_done = 1'b1; sum_ok = (mst != bad_step); end
            else begin sig_done = 1'b1; sig_ok = (mst != bad_step); end
         end else wcnt++;
      end else wcnt = 0;
   end

   task automatic run_case(input bit en, input logic [NK-1:0] mask, input int d,
                           input int lim, input int bad, input int hang, input int cycles);
      @(negedge clk); #1;
      rst_n = 1'b0;
      sec_en = en; revoke_mask = mask; dly = d; wdog_limit = 16'(lim);
      bad_step = bad; hang_step = hang;
      hash_value = (bad == 3) ? (FUSE ^ 256'd1) : FUSE;
      repeat (3) @(negedge clk);
      #1;
      go_cnt = 0; sig_cnt = 0; req_cnt = 0;
      rst_n = 1'b1;
      repeat (cycles) @(negedge clk);
      #1;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_err++;
         $display("FAIL R10 watchdog expired act=%0d exp=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (2) @(negedge clk);
      chk("R9 reset fail_code", fail_code, 0);
      chk("R9 reset fail", fail, 0);
      chk("R10 reset boot_go", boot_go, 0);

      run_case(1'b0, '0, 1, 20, -1, -1, 20);
      chk("R1 bypass go count", go_cnt, 1);
      chk("R1 bypass no requests", req_cnt, 0);

      run_case(1'b1, 16'h0000, 2, 20, -1, -1, 80);
      chk("R10 full chain go count", go_cnt, 1);
      chk("R10 full chain key", key_idx, 0);

      run_case(1'b1, 16'h00FF, 0, 20, -1, -1, 60);
      chk("R3 mask 00FF key", key_idx, 8);
      chk("R10 mask 00FF go", go_cnt, 1);

      run_case(1'b1, 16'h7FFF, 1, 20, -1, -1, 60);
      chk("R3 mask 7FFF key", key_idx, 15);

      run_case(1'b1, 16'hFFFF, 1, 20, -1, -1, 40);
      chk("R4 all revoked code", fail_code, 2);
      chk("R4 no signature request", sig_cnt, 0);

      run_case(1'b1, 16'h0000, 1, 20, 1, -1, 40);
      chk("R2 header checksum code", fail_code, 1);
      chk("R9 no go after fail", go_cnt, 0);

      run_case(1'b1, 16'h0000, 1, 20, 3, -1, 40);
      chk("R5 digest mismatch code", fail_code, 3);

      for (int s = 4; s <= 7; s++) begin
         run_case(1'b1, 16'h0010, 1, 20, s, -1, 60);
         chk("R6 step fail code", fail_code, s);
         chk("R9 fail held", fail, 1);
      end

      run_case(1'b1, 16'h0000, 1, 10, -1, 5, 80);
      chk("R8 hang at header signature", fail_code, 13);

      run_case(1'b1, 16'h0000, 9, 10, -1, -1, 120);
      chk("R8 done in last cycle passes", go_cnt, 1);

      run_case(1'b1, 16'h0000, 10, 10, -1, -1, 60);
      chk("R8 done one cycle late", fail_code, 9);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule